// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer Unit

This block holds three independent 32-bit timers that count down and sit behind a simple register bus. Each channel has a reload value, a live counter and a control word. A shared start register switches each channel on or off. Each channel takes its counting rate from one of six power-of-four divisions of the block clock, from a slow time-base tick input, or from an external tick input. When a channel ticks with its counter at zero, the counter reloads from the reload value, a sticky underflow flag sets, and the channel's interrupt line rises if its enable is on.

Software sets up a channel by writing the reload value, the counter and the control word, then sets the channel's bit in the start register. Each interrupt line follows the channel's flag ANDed with its enable, so the interrupt responds to any change of either one. Software acknowledges an event by writing 0 to the flag. A write can never create a flag, and an underflow that lands in the same cycle as a clear keeps the flag set.

Top module: `tmr3_unit`

## Requirements
- R1: After reset every counter, reload value, control word and the start register read 0, and all interrupt lines are 0.
- R2: Register map (byte addresses): start register at 0x00. Channel i occupies 12 bytes starting at 0x04 + 12*i: reload value at +0, counter at +4, control at +8. The control word has clock select in bits 2:0, interrupt enable in bit 5, underflow flag in bit 8 and a capture flag in bit 9. The start register uses bits 2:0. All other bits of the start and control registers read 0.
- R3: Bit i of the start register enables counting on channel i. While the bit is 0 the counter holds its value.
- R4: Clock select codes 0, 1, 2, 3, 4 and 5 make the counter decrement once every 4, 16, 64, 256, 1024 and 4096 block clocks.
- R5: Code 6 makes the channel decrement once per rising edge of the time-base tick input. Code 7 does the same for the external tick input. A tick input rising before clock edge E is counted at edge E+2.
- R6: A tick with the counter at 0 loads the counter from the reload value and sets the underflow flag.
- R7: A write to the control word cannot set the underflow flag. Writing 0 to bit 8 clears it, and writing 1 leaves it unchanged.
- R8: Each interrupt line equals that channel's underflow flag AND interrupt enable, and it updates in the cycle after a write or an underflow changes either one.
- R9: A counter write takes effect at once, also while the channel runs. Counting then continues from the written value at the next tick, with no restart delay.
- R10: If an underflow and a software clear of the flag fall in the same cycle, the flag stays set.
- R11: The channels are independent. Each one counts at its own selected rate, and writes to one channel do not affect another.
- R12: The capture flag (bit 9) is a plain read/write bit with no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rtc_tick_in | input | 1 | Slow time-base tick input (asynchronous) |
| ext_tick_in | input | 1 | External tick input (asynchronous) |
| irq_o | output | 3 | One interrupt line per channel |

## Verification
The prescale rates are measured as the counter change over a fixed window of 8192 clocks, which is a multiple of every division. Each channel is swept through all six divided codes, with the three channels on different codes at the same time. A wrong tap or a crossed channel therefore shows up as a different count. Pulse trains on the two tick inputs tell the external sources apart from each other and from the divided clock. Directed sequences drive a counter through zero, then step the enable and the flag in every order, which separates an interrupt that follows the AND from one that only latches. A clear that is timed to the exact underflow cycle shows whether the priority is right.

// File: rtl/tmr3_pkg.sv
// Package: shared sizes, field positions and the address map of the timer unit.
// Assumes byte addressing with 32-bit registers.
package tmr3_pkg;
    localparam int CNT_W    = 32;                 // counter / data width
    localparam int SEL_W    = 3;                  // clock-select width
    localparam int NUM_TAPS = 6;                  // power-of-four prescale taps
    localparam int PRE_W    = 2 * NUM_TAPS;       // prescaler width (12 -> /4096)
    localparam int NUM_SRC  = 1 << SEL_W;         // selectable tick sources

    // Control word field positions
    localparam int CTL_IE   = 5;
    localparam int CTL_UNF  = 8;
    localparam int CTL_CAP  = 9;

    // Address map
    localparam int START_ADDR = 0;
    localparam int GRP_BYTES  = 12;
    localparam int GRP_BASE   = 4;
    localparam int OFF_CONST  = 0;
    localparam int OFF_COUNT  = 4;
    localparam int OFF_CTL    = 8;

    // Base byte address of channel i's register group
    function automatic int ch_base(input int i);
        return GRP_BASE + GRP_BYTES * i;
    endfunction
endpackage

// File: rtl/tmr3_prescale.sv
// Free-running prescaler. It produces one single-cycle tick per tap, where tap k
// fires once every 4^(k+1) clocks, when the low 2(k+1) bits of the counter are
// all ones. Assumes the taps are only consumed as clock enables.
module tmr3_prescale
    import tmr3_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_TAPS-1:0] tap_tick
);
    logic [PRE_W-1:0] div_q;

    // Advance the shared division counter every clock
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // One tap per power of four: fires when its low bits wrap
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign tap_tick[k] = &div_q[2*k+1:0];
    end
endmodule

// File: rtl/tmr3_tick_sync.sv
// Brings an asynchronous tick input into the clock domain through two flops and
// emits a one-cycle pulse per rising edge. Assumes the input stays high and low
// for at least two clocks each.
module tmr3_tick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic [2:0] sync_q;

    // Two synchroniser stages plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], async_in};
    end

    assign rise_pulse = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/tmr3_channel.sv
// One timer channel: reload value, down-counter and control word. It picks its
// tick from the shared source vector, reloads on a tick at zero, and keeps a
// sticky underflow flag that a write can only clear. The interrupt is flag AND
// enable. Assumes at most one register write strobe per cycle.
module tmr3_channel
    import tmr3_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic               wr_const,
    input  logic               wr_count,
    input  logic               wr_ctl,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   const_o,
    output logic [CNT_W-1:0]   count_o,
    output logic [CNT_W-1:0]   ctl_o,
    output logic               flag_o,
    output logic               ie_o,
    output logic               uf_evt_o,
    output logic               irq_o
);
    logic [CNT_W-1:0] const_q, count_q;
    logic [SEL_W-1:0] sel_q;
    logic             ie_q, unf_q, cap_q;
    logic             tick;

    assign tick     = run & tick_src[sel_q];
    assign uf_evt_o = tick & (count_q == '0) & ~wr_count;

    // Hold the reload value
    always_ff @(posedge clk) begin
        if (!rst_n)        const_q <= '0;
        else if (wr_const) const_q <= wdata;
    end

    // Counter: a software write wins, otherwise decrement or reload on a tick
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (wr_count) count_q <= wdata;
        else if (uf_evt_o) count_q <= const_q;
        else if (tick)     count_q <= count_q - 1'b1;
    end

    // Plain control fields: select, enable, capture flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            ie_q  <= 1'b0;
            cap_q <= 1'b0;
        end else if (wr_ctl) begin
            sel_q <= wdata[SEL_W-1:0];
            ie_q  <= wdata[CTL_IE];
            cap_q <= wdata[CTL_CAP];
        end
    end

    // Sticky underflow flag: set by hardware, cleared only by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)        unf_q <= 1'b0;
        else if (uf_evt_o) unf_q <= 1'b1;
        else if (wr_ctl)   unf_q <= unf_q & wdata[CTL_UNF];
    end

    // Read-back image of the control word
    always_comb begin
        ctl_o             = '0;
        ctl_o[SEL_W-1:0]  = sel_q;
        ctl_o[CTL_IE]     = ie_q;
        ctl_o[CTL_UNF]    = unf_q;
        ctl_o[CTL_CAP]    = cap_q;
    end

    assign const_o = const_q;
    assign count_o = count_q;
    assign flag_o  = unf_q;
    assign ie_o    = ie_q;
    assign irq_o   = unf_q & ie_q;
endmodule

// File: rtl/tmr3_unit.sv
// Top of the three-channel timer unit: register decode, start register, shared
// prescaler, tick input synchronisers and the channel instances. Reads are
// combinational from bus_addr; writes take effect on the clock edge where
// bus_valid and bus_write are high. Reset is synchronous, active low.
module tmr3_unit
    import tmr3_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              rtc_tick_in,
    input  logic              ext_tick_in,
    output logic [NUM_CH-1:0] irq_o
);
    logic                    wr_en;
    logic [NUM_CH-1:0]       run_q;
    logic [NUM_TAPS-1:0]     tap_tick;
    logic                    rtc_pulse, ext_pulse;
    logic [NUM_SRC-1:0]      tick_src;
    logic [NUM_CH-1:0]       wr_const, wr_count, wr_ctl;
    logic [NUM_CH-1:0]       flag_vec, ie_vec, uf_evt_vec;
    logic [CNT_W-1:0]        const_arr [NUM_CH];
    logic [CNT_W-1:0]        count_arr [NUM_CH];
    logic [CNT_W-1:0]        ctl_arr   [NUM_CH];

    assign wr_en = bus_valid & bus_write;

    // Start register: one run bit per channel
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (wr_en && bus_addr == ADDR_W'(START_ADDR))
            run_q <= bus_wdata[NUM_CH-1:0];
    end

    tmr3_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_tick (tap_tick)
    );

    tmr3_tick_sync u_rtc_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (rtc_tick_in),
        .rise_pulse (rtc_pulse)
    );

    tmr3_tick_sync u_ext_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (ext_tick_in),
        .rise_pulse (ext_pulse)
    );

    // Source vector indexed by the clock-select code
    assign tick_src = {ext_pulse, rtc_pulse, tap_tick};

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = ch_base(i);

        assign wr_const[i] = wr_en && bus_addr == ADDR_W'(BASE + OFF_CONST);
        assign wr_count[i] = wr_en && bus_addr == ADDR_W'(BASE + OFF_COUNT);
        assign wr_ctl[i]   = wr_en && bus_addr == ADDR_W'(BASE + OFF_CTL);

        tmr3_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[i]),
            .tick_src (tick_src),
            .wr_const (wr_const[i]),
            .wr_count (wr_count[i]),
            .wr_ctl   (wr_ctl[i]),
            .wdata    (bus_wdata),
            .const_o  (const_arr[i]),
            .count_o  (count_arr[i]),
            .ctl_o    (ctl_arr[i]),
            .flag_o   (flag_vec[i]),
            .ie_o     (ie_vec[i]),
            .uf_evt_o (uf_evt_vec[i]),
            .irq_o    (irq_o[i])
        );
    end

    // Read multiplexer over the start register and all channel registers
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(START_ADDR))
            bus_rdata[NUM_CH-1:0] = run_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(ch_base(i) + OFF_CONST)) bus_rdata = const_arr[i];
            if (bus_addr == ADDR_W'(ch_base(i) + OFF_COUNT)) bus_rdata = count_arr[i];
            if (bus_addr == ADDR_W'(ch_base(i) + OFF_CTL))   bus_rdata = ctl_arr[i];
        end
    end
endmodule

// File: rtl/tmr3_unit_checker.sv
// Checker for tmr3_unit: temporal properties on the flag, the counter and the
// interrupt lines of every channel. It is attached with the bind below.
module tmr3_unit_checker
    import tmr3_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] run_q,
    input logic [NUM_CH-1:0] flag_vec,
    input logic [NUM_CH-1:0] ie_vec,
    input logic [NUM_CH-1:0] uf_evt_vec,
    input logic [NUM_CH-1:0] wr_count,
    input logic [NUM_CH-1:0] wr_ctl,
    input logic [NUM_CH-1:0] irq_o,
    input logic [CNT_W-1:0]  const_arr [NUM_CH],
    input logic [CNT_W-1:0]  count_arr [NUM_CH]
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R7: the flag only rises after a hardware underflow
        a_r7_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_vec[i]) |-> $past(uf_evt_vec[i]));

        // R10: with no control write, a set flag stays set
        a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_vec[i] && !wr_ctl[i]) |=> flag_vec[i]);

        // R3: a halted channel with no counter write keeps its count
        a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[i] && !wr_count[i]) |=> $stable(count_arr[i]));

        // R6: an underflow loads the reload value
        a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
            uf_evt_vec[i] |=> (count_arr[i] == $past(const_arr[i])));

        // R8: an underflow with the enable held raises the interrupt
        a_r8_irq_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            (uf_evt_vec[i] && ie_vec[i] && !wr_ctl[i]) |=> irq_o[i]);

        // R8: an interrupt line never rises without both flag and enable
        a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[i]) |-> (flag_vec[i] && ie_vec[i]));
    end
endmodule

bind tmr3_unit tmr3_unit_checker #(.NUM_CH(NUM_CH)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_q      (run_q),
    .flag_vec   (flag_vec),
    .ie_vec     (ie_vec),
    .uf_evt_vec (uf_evt_vec),
    .wr_count   (wr_count),
    .wr_ctl     (wr_ctl),
    .irq_o      (irq_o),
    .const_arr  (const_arr),
    .count_arr  (count_arr)
);

// File: tb/tmr3_unit_bench.sv
// Self-checking bench for tmr3_unit. It sweeps the prescale codes per channel,
// drives pulse trains on the tick inputs and walks the flag/enable/interrupt cases.
module tmr3_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rtc_tick_in = 1'b0;
    logic        ext_tick_in = 1'b0;
    logic [2:0]  irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tmr3_unit u_tmr3_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .rtc_tick_in (rtc_tick_in),
        .ext_tick_in (ext_tick_in),
        .irq_o       (irq_o)
    );

    function automatic logic [5:0] a_const(int ch); return 6'(4 + 12*ch);     endfunction
    function automatic logic [5:0] a_count(int ch); return 6'(4 + 12*ch + 4); endfunction
    function automatic logic [5:0] a_ctl(int ch);   return 6'(4 + 12*ch + 8); endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One write: it takes effect at the next rising edge and returns at the following negedge
    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // Combinational read that consumes no clock cycle
    task automatic rd(logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ext(bit use_rtc);
        if (use_rtc) rtc_tick_in = 1'b1; else ext_tick_in = 1'b1;
        cycles(4);
        if (use_rtc) rtc_tick_in = 1'b0; else ext_tick_in = 1'b0;
        cycles(4);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int div [6] = '{4, 16, 64, 256, 1024, 4096};

        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(6'd0, v); check("R1 start", v, 0);
        for (int c = 0; c < 3; c++) begin
            rd(a_const(c), v); check("R1 const", v, 0);
            rd(a_count(c), v); check("R1 count", v, 0);
            rd(a_ctl(c), v);   check("R1 ctl", v, 0);
        end
        check("R1 irq", {29'd0, irq_o}, 0);

        // R2: unused bits read 0; flag not settable (R7); capture flag read/write (R12)
        wr(a_ctl(1), 32'hFFFF_FFFF);
        rd(a_ctl(1), v); check("R2 ctl mask / R7 no set / R12 cap", v, 32'h0000_0227);
        check("R7 irq stays low", {31'd0, irq_o[1]}, 0);
        wr(a_ctl(1), 32'h0000_0000);
        rd(a_ctl(1), v); check("R12 cap clears", v, 0);
        wr(6'd0, 32'hFFFF_FFF8);
        rd(6'd0, v); check("R2 start mask", v, 0);

        // R4 / R11: sweep of the divided codes, a different code on each channel
        for (int c = 0; c < 6; c++) begin
            for (int ch = 0; ch < 3; ch++) begin
                wr(a_ctl(ch), 32'((c + ch) % 6));
                wr(a_count(ch), 32'd60000);
            end
            wr(6'd0, 32'h7);
            cycles(8192);
            for (int ch = 0; ch < 3; ch++) begin
                rd(a_count(ch), v);
                check($sformatf("R4 R11 code %0d ch %0d", (c + ch) % 6, ch),
                      v, 32'(60000 - 8192 / div[(c + ch) % 6]));
            end
            wr(6'd0, 32'h0);
        end

        // R3: a halted channel holds its count
        rd(a_count(0), v);
        cycles(300);
        begin
            logic [31:0] v2;
            rd(a_count(0), v2); check("R3 hold when halted", v2, v);
        end

        // R9: counter write while running; counting continues at once
        wr(a_ctl(0), 32'h0);
        wr(a_count(0), 32'd1000);
        wr(6'd0, 32'h1);
        cycles(40);
        wr(a_count(0), 32'd100);
        cycles(40);
        rd(a_count(0), v); check("R9 write while running", v, 32'd90);
        wr(6'd0, 32'h0);

        // R6: underflow reloads and sets the flag; no irq without the enable (R8)
        wr(a_const(1), 32'd5);
        wr(a_count(1), 32'd2);
        wr(a_ctl(1), 32'h0);
        wr(6'd0, 32'h2);
        cycles(12);
        rd(a_count(1), v); check("R6 reload", v, 32'd5);
        rd(a_ctl(1), v);   check("R6 flag set", v, 32'h100);
        check("R8 no irq without enable", {31'd0, irq_o[1]}, 0);
        wr(6'd0, 32'h0);

        // R8: the interrupt follows flag AND enable in every order
        wr(a_ctl(1), 32'h120);
        check("R8 enable with pending flag", {31'd0, irq_o[1]}, 1);
        check("R11 other irqs", {30'd0, irq_o[0], irq_o[2]}, 0);
        wr(a_ctl(1), 32'h100);
        check("R8 enable off drops irq", {31'd0, irq_o[1]}, 0);
        wr(a_ctl(1), 32'h120);
        check("R8 enable back on", {31'd0, irq_o[1]}, 1);
        wr(a_ctl(1), 32'h020);
        check("R7 clear drops irq", {31'd0, irq_o[1]}, 0);
        rd(a_ctl(1), v); check("R7 flag cleared", v, 32'h020);
        wr(a_ctl(1), 32'h120);
        rd(a_ctl(1), v); check("R7 write 1 cannot set", v, 32'h020);
        wr(a_count(1), 32'd0);
        wr(6'd0, 32'h2);
        cycles(4);
        check("R8 underflow with enable", {31'd0, irq_o[1]}, 1);
        wr(6'd0, 32'h0);

        // R5: tick inputs, code 7 external and code 6 time base
        wr(a_ctl(2), 32'h7);
        wr(a_count(2), 32'd50);
        wr(6'd0, 32'h4);
        for (int p = 0; p < 5; p++) pulse_ext(1'b0);
        for (int p = 0; p < 3; p++) pulse_ext(1'b1);
        rd(a_count(2), v); check("R5 external ticks only", v, 32'd45);
        wr(a_ctl(2), 32'h6);
        for (int p = 0; p < 4; p++) pulse_ext(1'b1);
        for (int p = 0; p < 2; p++) pulse_ext(1'b0);
        rd(a_count(2), v); check("R5 time-base ticks only", v, 32'd41);

        // R10: underflow and clear in the same cycle; the flag stays set
        wr(a_ctl(2), 32'h7);
        wr(a_const(2), 32'd9);
        wr(a_count(2), 32'd0);
        pulse_ext(1'b0);
        rd(a_ctl(2), v); check("R6 ext underflow flag", v, 32'h107);
        wr(a_count(2), 32'd0);
        ext_tick_in = 1'b1;          // before edge E1
        cycles(2);                   // after E1, E2: the counted edge is E3
        wr(a_ctl(2), 32'h007);       // clear lands on E3
        rd(a_ctl(2), v);   check("R10 underflow wins over clear", v, 32'h107);
        rd(a_count(2), v); check("R10 reload on race", v, 32'd9);
        cycles(3);
        ext_tick_in = 1'b0;
        cycles(4);
        wr(a_ctl(2), 32'h007);
        rd(a_ctl(2), v); check("R7 clear without race", v, 32'h007);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule